// File: doc/BRIEF.md
# In-band Autonegotiation Result Resolver

This block sits beside a serial Ethernet PCS and turns the 16-bit control word received from the link partner into link parameters for the MAC and the rate adapter. A two-bit mode input selects one of three word formats. In SGMII mode the word comes from a PHY and directly states speed, duplex and link. In 1000BASE-X and 2500BASE-X mode the word is an ability advertisement, and it must be combined with the local advertisement to resolve duplex and flow control. The mode input alone selects the format. The block never guesses the format from the word's contents, because reading a base-X advertisement with SGMII rules gives a false 10 Mb/s result.

Results are only taken once the partner word has stayed unchanged for a full link-timer period. The period depends on the mode: by default 100000 ticks (1.6 ms at a 16 ns tick) for SGMII and 625000 ticks (10 ms) for the base-X modes. A preset input can replace that length. Any change in the partner word, the local advertisement or the mode restarts the timer and withdraws the previous result. The reported speed code lets a downstream replicator choose its 1x, 10x or 100x factor.

Top module: `inband_an_resolver`

## Requirements
- R1: With tmr_ovr_i low, the link timer length is SGMII_TICKS (default 100000, 20-bit timer) when mode_i is 0 (SGMII). It is BASEX_TICKS (default 625000) when mode_i is 1 (1000BASE-X), 2 (2500BASE-X) or 3 (treated as 1000BASE-X). The result appears when the inputs have stayed unchanged for length+1 rising edges, and not one edge earlier.
- R2: With tmr_ovr_i high, the timer length is tmr_preset_i, and a preset of 0 is used as 1. The preset is captured when the timer restarts.
- R3: A change of lp_word_i, loc_adv_i or mode_i restarts the timer and drives done_o low after the next edge. Status outputs change only in the cycle the timer expires.
- R4: In base-X modes, duplex_o is 2 (full) if bit 5 is set in both words. Otherwise it is 1 (half) if bit 6 is set in both words. Otherwise it is 0 (unresolved), and valid_o stays low.
- R5: In base-X modes, pause is resolved from local and partner bit 7 (symmetric) and bit 8 (asymmetric). Both enables are set if both sides have bit 7. Only tx_pause_o is set if the local side has 0/1 (bit 7/bit 8) and the partner has 1/1. Only rx_pause_o is set if the local side has 1/1 and the partner has 0/1. In every other case both are clear.
- R6: In base-X modes, speed_o is 2 (1000 Mb/s), or 3 (2500 Mb/s) for mode 2, whatever the word contains. link_o is 1 and spd_err_o is 0.
- R7: In SGMII mode, partner bits 11:10 give speed_o: 00 gives 0 (10 Mb/s), 01 gives 1 (100 Mb/s), 10 gives 2 (1000 Mb/s). The value 11 sets spd_err_o, reports speed 0 and keeps valid_o low.
- R8: In SGMII mode, partner bit 12 gives duplex (1 → full code 2, 0 → half code 1). Bit 15 gives link_o. Both pause enables are 0, and the local advertisement does not affect the result.
- R9: While reset is asserted, done_o, valid_o and every status output are 0.
- R10: valid_o is high exactly when done_o is high, duplex is resolved and spd_err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 SGMII, 1 1000BASE-X, 2 2500BASE-X, 3 as 1000BASE-X |
| loc_adv_i | input | 16 | Local advertisement word (base-X format) |
| lp_word_i | input | 16 | Control word received from the link partner |
| tmr_ovr_i | input | 1 | Use tmr_preset_i instead of the mode default |
| tmr_preset_i | input | TMR_W (20) | Timer length when overridden |
| done_o | output | 1 | A result has been latched for the current inputs |
| valid_o | output | 1 | Result is usable (done, duplex resolved, no speed error) |
| speed_o | output | 2 | 0 10M, 1 100M, 2 1000M, 3 2500M |
| duplex_o | output | 2 | 0 unresolved, 1 half, 2 full |
| tx_pause_o | output | 1 | Send pause frames |
| rx_pause_o | output | 1 | Honour received pause frames |
| link_o | output | 1 | Partner reports link |
| spd_err_o | output | 1 | Reserved SGMII speed code received |

## Verification
Several properties are checked on every cycle. The timer count never exceeds the length it was loaded with. Expiry is a single-cycle event. Any input change withdraws done_o. valid_o never appears with an unresolved duplex or a speed error. A settled SGMII result never carries pause, and a settled 2500BASE-X result always reports 2500 Mb/s. Only the bench scenarios can show the rest: the exact expiry cycle for each preset and mode, the restart when the word changes partway through a count, the duplex and pause tables in base-X, and the field decoding in SGMII.

// File: rtl/an_res_pkg.sv
// Package: shared encodings and field positions for the in-band
// autonegotiation resolver. Assumes a 16-bit control word.
package an_res_pkg;

    localparam int CW_W = 16;

    // Base-X advertisement field positions
    localparam int BX_FD   = 5;
    localparam int BX_HD   = 6;
    localparam int BX_SYM  = 7;
    localparam int BX_ASYM = 8;

    // SGMII partner word field positions
    localparam int SG_SPD_LO = 10;
    localparam int SG_DPX    = 12;
    localparam int SG_LINK   = 15;

    typedef enum logic [1:0] {
        MODE_SGMII = 2'd0,
        MODE_1000X = 2'd1,
        MODE_2500X = 2'd2,
        MODE_RSVD  = 2'd3
    } an_mode_e;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_2500 = 2'd3
    } an_speed_e;

    typedef enum logic [1:0] {
        DPX_NONE = 2'd0,
        DPX_HALF = 2'd1,
        DPX_FULL = 2'd2,
        DPX_RSVD = 2'd3
    } an_dpx_e;

    typedef struct packed {
        an_speed_e speed;
        an_dpx_e   dpx;
        logic      tx_pause;
        logic      rx_pause;
        logic      link;
        logic      spd_err;
    } an_result_t;

endpackage

// File: rtl/an_link_timer.sv
// Link timer: reloads on restart_i with the mode default or an override
// preset (0 treated as 1), counts down one per tick and pulses expire_o
// in the cycle the count leaves 1. Assumes one tick per clk.
module an_link_timer
    import an_res_pkg::*;
#(
    parameter int TMR_W       = 20,
    parameter int SGMII_TICKS = 100000,
    parameter int BASEX_TICKS = 625000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  an_mode_e         mode_i,
    input  logic             ovr_i,
    input  logic [TMR_W-1:0] preset_i,
    output logic             expire_o
);

    localparam logic [TMR_W-1:0] SG_LEN = TMR_W'(SGMII_TICKS);
    localparam logic [TMR_W-1:0] BX_LEN = TMR_W'(BASEX_TICKS);
    localparam logic [TMR_W-1:0] ONE    = TMR_W'(1);

    logic [TMR_W-1:0] len_sel;
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] load_q;

    // Pick the timer length for the next restart
    always_comb begin
        if (ovr_i) begin
            len_sel = (preset_i == '0) ? ONE : preset_i;
        end else if (mode_i == MODE_SGMII) begin
            len_sel = SG_LEN;
        end else begin
            len_sel = BX_LEN;
        end
    end

    // Reload on restart, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else if (restart_i) begin
            cnt_q  <= len_sel;
            load_q <= len_sel;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Expiry is the last decrement of an uninterrupted count
    assign expire_o = (cnt_q == ONE) && !restart_i;

    p_cnt_bounded_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= load_q)
        else $error("timer count above loaded length");

    p_expire_single_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o)
        else $error("timer expired twice in a row");

endmodule

// File: rtl/an_pause_resolve.sv
// Pause resolution: combines local and partner symmetric/asymmetric
// pause abilities with the usual priority table into separate transmit
// and receive pause enables. Purely combinational.
module an_pause_resolve (
    input  logic loc_sym_i,
    input  logic loc_asym_i,
    input  logic lp_sym_i,
    input  logic lp_asym_i,
    output logic tx_pause_o,
    output logic rx_pause_o
);

    logic both_sym;
    logic tx_only;
    logic rx_only;

    // Classify the four ability bits into the three enabled cases
    always_comb begin
        both_sym = loc_sym_i && lp_sym_i;
        tx_only  = !loc_sym_i && loc_asym_i && lp_sym_i && lp_asym_i;
        rx_only  = loc_sym_i && loc_asym_i && !lp_sym_i && lp_asym_i;
    end

    assign tx_pause_o = both_sym || tx_only;
    assign rx_pause_o = both_sym || rx_only;

endmodule

// File: rtl/an_word_decode.sv
// Word decoder: interprets the partner word in the format chosen by the
// mode input only (SGMII status word or base-X advertisement) and forms
// a result. Assumes the local word is in base-X format.
module an_word_decode
    import an_res_pkg::*;
(
    input  an_mode_e        mode_i,
    input  logic [CW_W-1:0] loc_adv_i,
    input  logic [CW_W-1:0] lp_word_i,
    output an_result_t      res_o
);

    logic       bx_tx;
    logic       bx_rx;
    logic [1:0] sg_spd;

    an_pause_resolve u_pause (
        .loc_sym_i  (loc_adv_i[BX_SYM]),
        .loc_asym_i (loc_adv_i[BX_ASYM]),
        .lp_sym_i   (lp_word_i[BX_SYM]),
        .lp_asym_i  (lp_word_i[BX_ASYM]),
        .tx_pause_o (bx_tx),
        .rx_pause_o (bx_rx)
    );

    assign sg_spd = lp_word_i[SG_SPD_LO+1:SG_SPD_LO];

    // Decode the word under the selected format
    always_comb begin
        res_o = '0;
        if (mode_i == MODE_SGMII) begin
            res_o.spd_err  = (sg_spd == 2'b11);
            res_o.speed    = res_o.spd_err ? SPD_10 : an_speed_e'(sg_spd);
            res_o.dpx      = lp_word_i[SG_DPX] ? DPX_FULL : DPX_HALF;
            res_o.link     = lp_word_i[SG_LINK];
            res_o.tx_pause = 1'b0;
            res_o.rx_pause = 1'b0;
        end else begin
            res_o.speed = (mode_i == MODE_2500X) ? SPD_2500 : SPD_1000;
            if (lp_word_i[BX_FD] && loc_adv_i[BX_FD]) begin
                res_o.dpx = DPX_FULL;
            end else if (lp_word_i[BX_HD] && loc_adv_i[BX_HD]) begin
                res_o.dpx = DPX_HALF;
            end else begin
                res_o.dpx = DPX_NONE;
            end
            res_o.tx_pause = bx_tx;
            res_o.rx_pause = bx_rx;
            res_o.link     = 1'b1;
            res_o.spd_err  = 1'b0;
        end
    end

endmodule

// File: rtl/inband_an_resolver.sv
// Top: watches the partner word, local advertisement and mode for
// changes, restarts the link timer on any change, and latches the
// decoded result when the timer expires. Assumes synchronous inputs.
module inband_an_resolver
    import an_res_pkg::*;
#(
    parameter int TMR_W       = 20,
    parameter int SGMII_TICKS = 100000,
    parameter int BASEX_TICKS = 625000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [15:0]      loc_adv_i,
    input  logic [15:0]      lp_word_i,
    input  logic             tmr_ovr_i,
    input  logic [TMR_W-1:0] tmr_preset_i,
    output logic             done_o,
    output logic             valid_o,
    output logic [1:0]       speed_o,
    output logic [1:0]       duplex_o,
    output logic             tx_pause_o,
    output logic             rx_pause_o,
    output logic             link_o,
    output logic             spd_err_o
);

    an_mode_e        mode_e;
    logic [CW_W-1:0] word_q;
    logic [CW_W-1:0] adv_q;
    an_mode_e        mode_q;
    logic            first_q;
    logic            changed;
    logic            expire;
    an_result_t      dec_res;
    an_result_t      res_q;
    logic            done_q;

    assign mode_e = an_mode_e'(mode_i);

    // Remember last inputs to detect any change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            adv_q   <= '0;
            mode_q  <= MODE_SGMII;
            first_q <= 1'b1;
        end else begin
            word_q  <= lp_word_i;
            adv_q   <= loc_adv_i;
            mode_q  <= mode_e;
            first_q <= 1'b0;
        end
    end

    assign changed = first_q || (lp_word_i != word_q) ||
                     (loc_adv_i != adv_q) || (mode_e != mode_q);

    an_link_timer #(
        .TMR_W       (TMR_W),
        .SGMII_TICKS (SGMII_TICKS),
        .BASEX_TICKS (BASEX_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (changed),
        .mode_i    (mode_e),
        .ovr_i     (tmr_ovr_i),
        .preset_i  (tmr_preset_i),
        .expire_o  (expire)
    );

    an_word_decode u_dec (
        .mode_i    (mode_e),
        .loc_adv_i (loc_adv_i),
        .lp_word_i (lp_word_i),
        .res_o     (dec_res)
    );

    // Withdraw on change, latch the decoded result on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else if (changed) begin
            done_q <= 1'b0;
        end else if (expire) begin
            res_q  <= dec_res;
            done_q <= 1'b1;
        end
    end

    assign done_o     = done_q;
    assign valid_o    = done_q && (res_q.dpx != DPX_NONE) && !res_q.spd_err;
    assign speed_o    = res_q.speed;
    assign duplex_o   = res_q.dpx;
    assign tx_pause_o = res_q.tx_pause;
    assign rx_pause_o = res_q.rx_pause;
    assign link_o     = res_q.link;
    assign spd_err_o  = res_q.spd_err;

    p_word_change_clears_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (lp_word_i != $past(lp_word_i)) |=> !done_o)
        else $error("done held across a word change");

    p_status_only_on_expiry_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> ($stable(speed_o) && $stable(duplex_o) &&
                                       $stable(link_o)))
        else $error("status moved while settled");

    p_valid_needs_dpx_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (done_o && duplex_o != 2'd0 && !spd_err_o))
        else $error("valid without resolution");

    p_sgmii_no_pause_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_i == 2'd0 && $stable(mode_i)) |-> (!tx_pause_o && !rx_pause_o))
        else $error("pause reported in SGMII mode");

    p_2500_speed_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_i == 2'd2 && $stable(mode_i)) |-> (speed_o == 2'd3))
        else $error("2500BASE-X result not at 2500");

endmodule

// File: tb/inband_an_resolver_tb_top.sv
// Bench: directed corner cases plus seeded random words, compared with
// a model written from the requirements.
module inband_an_resolver_tb_top;

    localparam int TMR_W = 20;
    localparam int SG_T  = 40;
    localparam int BX_T  = 250;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = '0;
    logic [15:0]      loc_adv_i = '0;
    logic [15:0]      lp_word_i = '0;
    logic             tmr_ovr_i = 1'b0;
    logic [TMR_W-1:0] tmr_preset_i = '0;
    logic             done_o, valid_o, tx_pause_o, rx_pause_o, link_o, spd_err_o;
    logic [1:0]       speed_o, duplex_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    inband_an_resolver #(.TMR_W(TMR_W), .SGMII_TICKS(SG_T), .BASEX_TICKS(BX_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .loc_adv_i(loc_adv_i),
        .lp_word_i(lp_word_i), .tmr_ovr_i(tmr_ovr_i), .tmr_preset_i(tmr_preset_i),
        .done_o(done_o), .valid_o(valid_o), .speed_o(speed_o), .duplex_o(duplex_o),
        .tx_pause_o(tx_pause_o), .rx_pause_o(rx_pause_o), .link_o(link_o),
        .spd_err_o(spd_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {speed, duplex, tx, rx, link, err} per R4-R8
    function automatic logic [7:0] model(input logic [1:0] m, input logic [15:0] adv,
                                         input logic [15:0] w);
        logic [1:0] spd, dpx;
        logic tx, rx, lk, er;
        if (m == 2'd0) begin
            er  = (w[11:10] == 2'b11);
            spd = er ? 2'd0 : w[11:10];
            dpx = w[12] ? 2'd2 : 2'd1;
            tx = 1'b0; rx = 1'b0;
            lk  = w[15];
        end else begin
            er  = 1'b0;
            spd = (m == 2'd2) ? 2'd3 : 2'd2;
            dpx = (w[5] && adv[5]) ? 2'd2 : ((w[6] && adv[6]) ? 2'd1 : 2'd0);
            tx  = (adv[7] && w[7]) || (!adv[7] && adv[8] && w[7] && w[8]);
            rx  = (adv[7] && w[7]) || (adv[7] && adv[8] && !w[7] && w[8]);
            lk  = 1'b1;
        end
        return {spd, dpx, tx, rx, lk, er};
    endfunction

    function automatic int tlen(input logic [1:0] m, input logic ovr, input logic [TMR_W-1:0] pre);
        if (ovr) return (pre == 0) ? 1 : int'(pre);
        return (m == 2'd0) ? SG_T : BX_T;
    endfunction

    function automatic logic [7:0] outs();
        return {speed_o, duplex_o, tx_pause_o, rx_pause_o, link_o, spd_err_o};
    endfunction

    // Apply one input set, check the expiry cycle and the settled result
    task automatic run_case(input string req, input logic [1:0] m, input logic [15:0] adv,
                            input logic [15:0] w, input logic ovr, input logic [TMR_W-1:0] pre);
        logic [7:0] e;
        int n;
        @(negedge clk);
        mode_i = m; loc_adv_i = adv; tmr_ovr_i = ovr; tmr_preset_i = pre;
        lp_word_i = ~w;
        @(negedge clk);
        lp_word_i = w;
        n = tlen(m, ovr, pre);
        repeat (n) @(negedge clk);
        check({req, " R1 not early"}, {31'd0, done_o}, 32'd0);
        @(negedge clk);
        check({req, " R1 expiry"}, {31'd0, done_o}, 32'd1);
        e = model(m, adv, w);
        check(req, {24'd0, outs()}, {24'd0, e});
        check({req, " R10 valid"}, {31'd0, valid_o}, {31'd0, (e[5:4] != 2'd0) && !e[0]});
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 reset", {22'd0, done_o, valid_o, outs()}, 32'd0);
        rst_n = 1'b1;

        // R1 defaults per mode
        run_case("R1 sgmii default", 2'd0, 16'h0000, 16'hD800, 1'b0, '0);
        run_case("R1 basex default", 2'd1, 16'h01A0, 16'h00E0, 1'b0, '0);
        run_case("R1 mode3 default", 2'd3, 16'h0020, 16'h0020, 1'b0, '0);
        // R4 R5 key case: full duplex, symmetric pause
        run_case("R4 R5 0x00E0", 2'd1, 16'h01A0, 16'h00E0, 1'b1, 20'd5);
        // R4 half and unresolved
        run_case("R4 half", 2'd1, 16'h0040, 16'h0060, 1'b1, 20'd3);
        run_case("R4 unresolved", 2'd1, 16'h0020, 16'h0040, 1'b1, 20'd3);
        // R5 pause table corners
        run_case("R5 tx only", 2'd1, 16'h0120, 16'h01A0, 1'b1, 20'd2);
        run_case("R5 rx only", 2'd1, 16'h01A0, 16'h0120, 1'b1, 20'd2);
        run_case("R5 none", 2'd1, 16'h0120, 16'h0120, 1'b1, 20'd2);
        // R6 speed fixed regardless of word
        run_case("R6 2500", 2'd2, 16'h0020, 16'h0C20, 1'b1, 20'd4);
        run_case("R6 1000 sgmii-like word", 2'd1, 16'h0020, 16'h0020, 1'b1, 20'd4);
        // R7 SGMII speed codes
        run_case("R7 10M", 2'd0, 16'h0000, 16'h9000, 1'b1, 20'd3);
        run_case("R7 100M", 2'd0, 16'h0000, 16'h8400, 1'b1, 20'd3);
        run_case("R7 reserved", 2'd0, 16'h0000, 16'h9C00, 1'b1, 20'd3);
        // R8 duplex, link, pause, local adv ignored
        run_case("R8 half nolink", 2'd0, 16'hFFFF, 16'h0800, 1'b1, 20'd3);
        run_case("R8 adv ignored", 2'd0, 16'h0000, 16'h0800, 1'b1, 20'd3);
        // R2 preset zero as one
        run_case("R2 preset0", 2'd1, 16'h0020, 16'h0020, 1'b1, 20'd0);

        // R3 done withdrawn on word change and on adv change
        @(negedge clk); lp_word_i = lp_word_i ^ 16'h0001;
        @(negedge clk);
        check("R3 word change clears done", {31'd0, done_o}, 32'd0);
        run_case("R3 setup", 2'd1, 16'h0020, 16'h0020, 1'b1, 20'd2);
        @(negedge clk); loc_adv_i = 16'h0040;
        @(negedge clk);
        check("R3 adv change clears done", {31'd0, done_o}, 32'd0);

        // R3 restart in the middle of a count
        begin
            @(negedge clk);
            mode_i = 2'd0; tmr_ovr_i = 1'b1; tmr_preset_i = 20'd8; lp_word_i = 16'h0000;
            @(negedge clk); lp_word_i = 16'hD800;
            repeat (6) @(negedge clk);
            lp_word_i = 16'h9400;
            repeat (8) @(negedge clk);
            check("R3 restart not early", {31'd0, done_o}, 32'd0);
            @(negedge clk);
            check("R3 restart expiry", {31'd0, done_o}, 32'd1);
            check("R3 latched new word", {24'd0, outs()}, {24'd0, model(2'd0, 16'h0, 16'h9400)});
        end

        // Random mix, R2 and decode rules
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  m;
            logic [15:0] a, w;
            m = 2'($urandom_range(0, 3));
            a = 16'($urandom());
            w = 16'($urandom());
            run_case("R2 random", m, a, w, 1'b1, 20'($urandom_range(0, 12)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule